// File: doc/BRIEF.md
# Timer Clock Select Prescaler

This block feeds a timer counter with a count-enable tick. It stays in the system clock domain and never makes a derived clock. A 3-bit select code chooses where the tick comes from. The choices are: no ticks at all, a tick on every clock, a tick once every 8, 64, 256 or 1024 clocks, or a tick once per falling or rising transition of an external pin.

All the divided rates come from one shared free-running 10-bit counter, so their phases stay aligned with each other. Before edge detection, the external pin passes through a two-flop synchronizer. A separate clear input restarts the shared counter, so the timer can begin a divided interval from a known point. The tick output is registered and lasts exactly one clock each time it fires, except in the every-clock mode, where it stays high.

Top module: `tick_prescaler`

## Requirements
- R1: While `rst` is high at a clock edge, the tick output is low after that edge and the shared counter returns to zero.
- R2: Select code 3'b000 produces no ticks.
- R3: Select code 3'b001 holds the tick high after every clock edge that follows reset release.
- R4: Select codes 3'b010, 3'b011, 3'b100 and 3'b101 give a one-clock tick every 8, 64, 256 and 1024 clocks. The first tick follows the N-th clock edge after the last reset edge, where N is the ratio.
- R5: A high `presc_clr` at a clock edge zeroes the shared counter and suppresses any divided tick at that edge. The next divided tick then follows the N-th edge after the clearing edge.
- R6: Select code 3'b111 gives one tick per rising transition of `ext_pin`, and 3'b110 gives one tick per falling transition. The tick is high after the third clock edge following the pin change, for one clock. The pin must hold each level for at least two clocks.
- R7: Activity on `ext_pin` has no effect on the tick in any mode other than 3'b110 and 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Tick source select code |
| presc_clr | input | 1 | Restarts the shared division counter |
| ext_pin | input | 1 | Asynchronous external event pin |
| tick | output | 1 | One-clock count-enable for the timer |

## Verification
The bench sweeps every divided ratio over several full periods and checks the tick on every clock. An off-by-one tap width or a wrong ratio shows up as a tick one clock early or late, or at twice the rate. It then clears the counter exactly at the edge where a tick was due. A design that lets that tick through, or does not restart the count, puts the next tick in the wrong place. External pulses of width two, three and five clocks are sent in both edge modes. These catch a missing synchronizer stage, which makes the tick one clock early, and an inverted edge choice, which puts the tick at the wrong end of the pulse. The pin toggles every clock in the stopped and divided modes, so any leak of the pin into those modes shows up as extra ticks.

// File: rtl/tick_prescaler_pkg.sv
package tick_prescaler_pkg;

    // Tick source select codes
    typedef enum logic [2:0] {
        SEL_STOP     = 3'd0,
        SEL_DIV1     = 3'd1,
        SEL_DIV8     = 3'd2,
        SEL_DIV64    = 3'd3,
        SEL_DIV256   = 3'd4,
        SEL_DIV1024  = 3'd5,
        SEL_PIN_FALL = 3'd6,
        SEL_PIN_RISE = 3'd7
    } clk_sel_e;

    // Number of divided taps taken from the shared counter
    localparam int unsigned N_TAPS = 4;

    // log2 of the ratio for each tap, tap 0 being the smallest
    function automatic int unsigned tap_log2(int unsigned idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

    // Candidate tick sources gathered before selection
    typedef struct packed {
        logic [N_TAPS-1:0] div;
        logic              pin_rise;
        logic              pin_fall;
    } tick_src_t;

    function automatic logic is_divided(clk_sel_e s);
        return (s == SEL_DIV8) || (s == SEL_DIV64) ||
               (s == SEL_DIV256) || (s == SEL_DIV1024);
    endfunction

    // Map a divided select code onto its tap index
    function automatic logic [1:0] tap_index(clk_sel_e s);
        logic [2:0] d;
        d = 3'(s) - 3'd2;
        return d[1:0];
    endfunction

endpackage

// File: rtl/presc_counter.sv
module presc_counter
    import tick_prescaler_pkg::*;
#(
    parameter int unsigned DIV_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clr_i,
    output logic [N_TAPS-1:0] tap_o
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // A tap fires when its low counter bits are all ones; a clear masks it
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int unsigned L = tap_log2(g);
        assign tap_o[g] = !clr_i && (&cnt_q[L-1:0]);
    end

    // R5: a clear leaves the counter at zero on the next cycle
    a_r5_clear_zeroes: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (cnt_q == '0));

    // R4: without a clear the counter advances by one each clock
    a_r4_free_running: assert property (@(posedge clk_i) disable iff (rst_i)
        !clr_i |=> (cnt_q == ($past(cnt_q) + DIV_W'(1))));

endmodule

// File: rtl/pin_edge_sync.sv
module pin_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise_o =  sync_q[SYNC_STAGES-1] && !last_q;
    assign fall_o = !sync_q[SYNC_STAGES-1] &&  last_q;

    // R6: each detected transition lasts a single clock
    a_r6_rise_single: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);
    a_r6_fall_single: assert property (@(posedge clk_i) disable iff (rst_i)
        fall_o |=> !fall_o);

endmodule

// File: rtl/tick_select.sv
module tick_select
    import tick_prescaler_pkg::*;
(
    input  clk_sel_e  sel_i,
    input  tick_src_t src_i,
    output logic      tick_o
);

    always_comb begin
        tick_o = 1'b0;
        case (sel_i)
            SEL_STOP:     tick_o = 1'b0;
            SEL_DIV1:     tick_o = 1'b1;
            SEL_PIN_FALL: tick_o = src_i.pin_fall;
            SEL_PIN_RISE: tick_o = src_i.pin_rise;
            default:      tick_o = src_i.div[tap_index(sel_i)];
        endcase
    end

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import tick_prescaler_pkg::*;
#(
    parameter int unsigned DIV_W       = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] clk_sel,
    input  logic       presc_clr,
    input  logic       ext_pin,
    output logic       tick
);

    clk_sel_e  sel;
    tick_src_t src;
    logic      tick_d;
    logic      tick_q;

    assign sel = clk_sel_e'(clk_sel);

    presc_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk_i (clk),
        .rst_i (rst),
        .clr_i (presc_clr),
        .tap_o (src.div)
    );

    pin_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk_i  (clk),
        .rst_i  (rst),
        .pin_i  (ext_pin),
        .rise_o (src.pin_rise),
        .fall_o (src.pin_fall)
    );

    tick_select u_sel (
        .sel_i  (sel),
        .src_i  (src),
        .tick_o (tick_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= tick_d;
        end
    end

    assign tick = tick_q;

    // R2: stopped mode gives no tick
    a_r2_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_STOP) |=> !tick);

    // R3: every-clock mode keeps the tick high
    a_r3_every_clock: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_DIV1) |=> tick);

    // R4: a divided tick is never followed by another one
    a_r4_divided_single: assert property (@(posedge clk) disable iff (rst)
        (tick && is_divided(sel) && $stable(clk_sel)) |=> !tick);

endmodule

// File: tb/tick_prescaler_test.sv
module tick_prescaler_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] clk_sel = 3'd0;
    logic       presc_clr = 1'b0;
    logic       ext_pin = 1'b0;
    logic       tick;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    tick_prescaler uut (
        .clk       (clk),
        .rst       (rst),
        .clk_sel   (clk_sel),
        .presc_clr (presc_clr),
        .ext_pin   (ext_pin),
        .tick      (tick)
    );

    task automatic check(input string req, input logic act, input logic exp, input int idx);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at step %0d: tick=%b expected %b", req, idx, act, exp);
        end
    endtask

    // Advance one clock edge; return at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R1: hold reset for three edges with the select applied, tick must stay low
    task automatic do_reset(input logic [2:0] code);
        rst = 1'b1;
        clk_sel = code;
        presc_clr = 1'b0;
        ext_pin = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R1", tick, 1'b0, i);
        end
        rst = 1'b0;
    endtask

    function automatic int ratio_of(input logic [2:0] code);
        case (code)
            3'd2:    return 8;
            3'd3:    return 64;
            3'd4:    return 256;
            default: return 1024;
        endcase
    endfunction

    // R6: one pulse of width w on the pin
    task automatic pin_pulse(input logic [2:0] code, input int w);
        do_reset(code);
        for (int i = 0; i < 4; i++) begin
            step();
            check("R6", tick, 1'b0, i);
        end
        ext_pin = 1'b1;
        for (int i = 1; i <= w + 6; i++) begin
            step();
            check("R6", tick, (code == 3'd7) ? (i == 3) : (i == w + 3), i);
            if (i == w) ext_pin = 1'b0;
        end
    endtask

    initial begin
        @(negedge clk);

        // R2 and R7: stopped mode with a busy pin
        do_reset(3'd0);
        for (int k = 1; k <= 40; k++) begin
            ext_pin = ~ext_pin;
            step();
            check("R2", tick, 1'b0, k);
        end

        // R3: tick on every clock
        do_reset(3'd1);
        for (int k = 1; k <= 20; k++) begin
            step();
            check("R3", tick, 1'b1, k);
        end

        // R4, R5, R7: every divided ratio, pin toggling throughout
        for (int code = 2; code <= 5; code++) begin
            int n;
            n = ratio_of(3'(code));
            do_reset(3'(code));
            for (int k = 1; k < 3 * n; k++) begin
                ext_pin = ~ext_pin;
                step();
                check("R4", tick, (k % n) == 0, k);
            end
            // The clear lands on the edge where a tick was due
            presc_clr = 1'b1;
            step();
            check("R5", tick, 1'b0, 0);
            presc_clr = 1'b0;
            for (int j = 1; j <= 2 * n + 1; j++) begin
                ext_pin = ~ext_pin;
                step();
                check("R5", tick, (j % n) == 0, j);
            end
        end

        // R6: both edge modes, several pulse widths
        pin_pulse(3'd7, 2);
        pin_pulse(3'd7, 3);
        pin_pulse(3'd7, 5);
        pin_pulse(3'd6, 2);
        pin_pulse(3'd6, 3);
        pin_pulse(3'd6, 5);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #2000000;
        mismatched++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule